// File: doc/BRIEF.md
# Reference Impairment Monitor with Holdover Capture

This block sits beside a digital PLL and decides whether the reference clock feeding the loop can be trusted. It brings the reference into the master clock domain and counts its rising edges over a fixed measurement window timed by the master clock. It compares each window's count against a programmable lower and upper limit. Any window outside those limits raises an impairment flag, which the loop treats as a request to enter holdover. A dead reference, a reference that has jumped in frequency, and a reference outside the limits are all caught by the same comparison.

While the reference is healthy, the block keeps a two-deep history of the loop's frequency control word. The live word is sampled once per snapshot period, which is a fixed number of good windows. When impairment begins, the older of the two samples becomes the holdover word. That sample therefore describes loop behaviour from between one and two snapshot periods before the fault. Sizing one period at 30 ms gives holdover a word that is 30 to 60 ms old.

The history freezes while the flag is set, so samples taken during the fault never reach it. The flag clears only after two consecutive good windows. A phase-keep output stays high for the whole impairment and for one further window after recovery. During that time the loop resumes without realigning phase, so the input-to-output offset it had before holdover is kept.

Top module: `refmon_top`

## Requirements
- R1: At the end of each measurement window, a rising-edge count below `lim_lo_i` or above `lim_hi_i` sets `impaired_o` on the next clock. Both limits are inclusive bounds of the good range.
- R2: A window in which the reference has no rising edge at all sets `impaired_o`.
- R3: A step in reference frequency that pushes the count above the upper limit sets `impaired_o`, even though edges are still arriving.
- R4: `impaired_o` clears only at the end of the second consecutive in-range window. A single in-range window after a bad one leaves it set, and it only ever falls in the clock after a window ends.
- R5: After reset, `impaired_o` is 1, `keep_phase_o` is 1 and `hold_word_o` is 0. The flag stays set until at least two full in-range windows have completed.
- R6: On the window end that sets `impaired_o`, `hold_word_o` loads the older history stage. It then holds that value, unchanged, for as long as the flag stays set.
- R7: Every `SNAP_WINDOWS` in-range windows seen while unimpaired, the live `freq_word_i` enters the newer history stage and the newer stage moves to the older one. As a result, a word that has been steady for two full snapshot periods before impairment is the one reported on `hold_word_o`.
- R8: While `impaired_o` is set, the history does not advance. Values of `freq_word_i` applied only during impairment, or during the out-of-range window that starts it, never appear on `hold_word_o` at the next holdover entry.
- R9: `keep_phase_o` is 1 whenever `impaired_o` is 1. It stays 1 through the first full window after the flag clears, then falls at the end of that window if the window was in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference clock, asynchronous to clk |
| freq_word_i | input | FW | Live frequency control word from the loop filter |
| lim_lo_i | input | CNT_W | Lowest acceptable edge count per window |
| lim_hi_i | input | CNT_W | Highest acceptable edge count per window |
| impaired_o | output | 1 | Reference unusable; the loop must hold over |
| hold_word_o | output | FW | Frequency word to use during holdover |
| keep_phase_o | output | 1 | Suppress phase realignment on resumption |

## Verification
The assertions check, on every cycle, the following:
- an out-of-range or empty window always raises the flag;
- the flag only falls right after a window ends;
- the holdover word never moves while the flag stays set;
- the older history stage never moves while impaired;
- the phase-keep output covers the whole impairment.

Only the bench's scenarios can show the behaviour over time. This covers how many windows recovery takes, and that a dead, too-fast or too-slow reference is classified correctly. It also covers which earlier frequency word is chosen after long steady periods, and that words applied during a fault are kept out of the next holdover capture.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_BAD  = 2'd1,
    VERD_GOOD = 2'd2
  } verdict_e;

endpackage

// File: rtl/refmon_edge_sync.sv
module refmon_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], async_i};
      last  <= chain[SYNC_STAGES-1];
    end
  end

  assign rise_o = chain[SYNC_STAGES-1] & ~last;

endmodule

// File: rtl/refmon_window.sv
module refmon_window #(
  parameter int WIN_CYCLES = 64,
  parameter int CNT_W      = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int TICK_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(WIN_CYCLES - 1);

  logic [TICK_W-1:0] tick;
  logic [CNT_W-1:0]  acc;
  logic              at_end;
  logic [CNT_W-1:0]  acc_next;

  assign at_end   = (tick == TICK_LAST);
  assign acc_next = acc + CNT_W'(edge_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      acc     <= '0;
      done_o  <= 1'b0;
      count_o <= '0;
    end else begin
      done_o <= at_end;
      if (at_end) begin
        tick    <= '0;
        acc     <= '0;
        count_o <= acc_next;
      end else begin
        tick <= tick + 1'b1;
        acc  <= acc_next;
      end
    end
  end

endmodule

// File: rtl/refmon_judge.sv
module refmon_judge
  import refmon_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int CLEAR_WINS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             impaired_o,
  output logic             keep_o,
  output logic             enter_o,
  output logic             advance_o
);

  localparam int STRK_W = $clog2(CLEAR_WINS + 1);
  localparam logic [STRK_W-1:0] STRK_LAST = STRK_W'(CLEAR_WINS - 1);

  verdict_e          verdict;
  logic [STRK_W-1:0] streak;

  always_comb begin
    verdict = VERD_NONE;
    if (done_i) begin
      if ((count_i < lo_i) || (count_i > hi_i) || (count_i == '0))
        verdict = VERD_BAD;
      else
        verdict = VERD_GOOD;
    end
  end

  assign enter_o   = (verdict == VERD_BAD)  && !impaired_o;
  assign advance_o = (verdict == VERD_GOOD) && !impaired_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      impaired_o <= 1'b1;
      keep_o     <= 1'b1;
      streak     <= '0;
    end else begin
      case (verdict)
        VERD_BAD: begin
          impaired_o <= 1'b1;
          keep_o     <= 1'b1;
          streak     <= '0;
        end
        VERD_GOOD: begin
          if (impaired_o) begin
            if (streak == STRK_LAST) begin
              impaired_o <= 1'b0;
              streak     <= '0;
            end else begin
              streak <= streak + 1'b1;
            end
          end else begin
            keep_o <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/refmon_history.sv
module refmon_history #(
  parameter int FW           = 24,
  parameter int SNAP_WINDOWS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance_i,
  input  logic          enter_i,
  input  logic [FW-1:0] word_i,
  output logic [FW-1:0] older_o,
  output logic [FW-1:0] hold_o
);

  localparam int SNAP_W = (SNAP_WINDOWS > 1) ? $clog2(SNAP_WINDOWS) : 1;
  localparam logic [SNAP_W-1:0] SNAP_LAST = SNAP_W'(SNAP_WINDOWS - 1);

  logic [SNAP_W-1:0] snap_cnt;
  logic [FW-1:0]     newer;
  logic              shift;

  assign shift = advance_i && (snap_cnt == SNAP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_cnt <= '0;
      newer    <= '0;
      older_o  <= '0;
    end else if (advance_i) begin
      if (shift) begin
        snap_cnt <= '0;
        newer    <= word_i;
        older_o  <= newer;
      end else begin
        snap_cnt <= snap_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      hold_o <= '0;
    else if (enter_i)
      hold_o <= older_o;
  end

endmodule

// File: rtl/refmon_top.sv
module refmon_top #(
  parameter int FW           = 24,
  parameter int WIN_CYCLES   = 64,
  parameter int SNAP_WINDOWS = 4,
  parameter int CLEAR_WINS   = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_i,
  input  logic [FW-1:0]    freq_word_i,
  input  logic [CNT_W-1:0] lim_lo_i,
  input  logic [CNT_W-1:0] lim_hi_i,
  output logic             impaired_o,
  output logic [FW-1:0]    hold_word_o,
  output logic             keep_phase_o
);

  logic             ref_rise;
  logic             win_done;
  logic [CNT_W-1:0] meas;
  logic             enter;
  logic             advance;
  logic [FW-1:0]    stage_b;

  refmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(ref_i), .rise_o(ref_rise)
  );

  refmon_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .edge_i(ref_rise), .done_o(win_done), .count_o(meas)
  );

  refmon_judge #(.CNT_W(CNT_W), .CLEAR_WINS(CLEAR_WINS)) u_judge (
    .clk(clk), .rst(rst), .done_i(win_done), .count_i(meas),
    .lo_i(lim_lo_i), .hi_i(lim_hi_i),
    .impaired_o(impaired_o), .keep_o(keep_phase_o),
    .enter_o(enter), .advance_o(advance)
  );

  refmon_history #(.FW(FW), .SNAP_WINDOWS(SNAP_WINDOWS)) u_hist (
    .clk(clk), .rst(rst), .advance_i(advance), .enter_i(enter),
    .word_i(freq_word_i), .older_o(stage_b), .hold_o(hold_word_o)
  );

endmodule

// File: rtl/refmon_chk.sv
module refmon_chk #(
  parameter int FW    = 24,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             win_done,
  input logic [CNT_W-1:0] meas,
  input logic [CNT_W-1:0] lo,
  input logic [CNT_W-1:0] hi,
  input logic             imp,
  input logic [FW-1:0]    hold,
  input logic             keep,
  input logic [FW-1:0]    stage_b
);

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst) (win_done && (meas < lo || meas > hi)) |=> imp); // R1
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst) (win_done && meas == '0) |=> imp); // R2
  AST_CLEAR_AT_WINDOW: assert property (@(posedge clk) disable iff (rst) $fell(imp) |-> $past(win_done)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) (imp && $past(imp)) |-> $stable(hold)); // R6
  AST_HISTORY_FROZEN: assert property (@(posedge clk) disable iff (rst) imp |=> $stable(stage_b)); // R8
  AST_KEEP_COVERS: assert property (@(posedge clk) disable iff (rst) imp |-> keep); // R9

endmodule

bind refmon_top refmon_chk #(.FW(FW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .win_done(win_done), .meas(meas),
  .lo(lim_lo_i), .hi(lim_hi_i), .imp(impaired_o), .hold(hold_word_o),
  .keep(keep_phase_o), .stage_b(stage_b)
);

// File: tb/refmon_top_tb.sv
module refmon_top_tb;

  localparam int FW = 24;
  localparam int WIN = 64;
  localparam int CW = $clog2(WIN + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_i = 1'b0;
  logic [FW-1:0] freq_word = '0;
  logic [CW-1:0] lim_lo = CW'(6);
  logic [CW-1:0] lim_hi = CW'(10);
  logic          impaired, keep;
  logic [FW-1:0] hold;

  int  errors = 0;
  int  checks = 0;
  bit  ref_en = 1'b0;
  int  ref_half = 32;

  always #4 clk = ~clk;

  always begin
    if (ref_en) begin
      #(ref_half) ref_i = ~ref_i;
    end else begin
      ref_i = 1'b0;
      #8;
    end
  end

  refmon_top #(.FW(FW), .WIN_CYCLES(WIN), .SNAP_WINDOWS(4), .CLEAR_WINS(2)) u_dut (
    .clk(clk), .rst(rst), .ref_i(ref_i), .freq_word_i(freq_word),
    .lim_lo_i(lim_lo), .lim_hi_i(lim_hi),
    .impaired_o(impaired), .hold_word_o(hold), .keep_phase_o(keep)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ref(input int period_cycles);
    ref_half = period_cycles * 4;
    ref_en = 1'b1;
  endtask

  task automatic wait_clear(output int waited);
    waited = 0;
    while (impaired && waited < 2000) begin
      cyc(1);
      waited++;
    end
  endtask

  task automatic t_reset;
    cyc(1);
    chk("R5 flag after reset", impaired, 1);
    chk("R5 keep after reset", keep, 1);
    chk("R5 hold after reset", hold, 0);
  endtask

  task automatic t_first_lock;
    int w;
    cyc(100);
    chk("R5 flag held before two windows", impaired, 1);
    wait_clear(w);
    chk("R4 cleared within bound", (w > 0 && w < 200) ? 1 : 0, 1);
    cyc(20);
    chk("R9 keep after clear", keep, 1);
    cyc(WIN + 10);
    chk("R9 keep falls after a good window", keep, 0);
  endtask

  task automatic t_limits;
    int w;
    lim_hi = CW'(5);
    cyc(2 * WIN + 10);
    chk("R1 count above hi limit", impaired, 1);
    lim_hi = CW'(10);
    lim_lo = CW'(6);
    wait_clear(w);
    chk("R4 recovery takes more than one window", (w > WIN && w < 4 * WIN) ? 1 : 0, 1);
  endtask

  task automatic t_loss;
    int w;
    ref_en = 1'b0;
    cyc(2 * WIN + 10);
    chk("R2 dead reference", impaired, 1);
    chk("R9 keep during loss", keep, 1);
    set_ref(8);
    wait_clear(w);
    chk("R4 recovery after loss", (w > WIN && w < 4 * WIN) ? 1 : 0, 1);
  endtask

  task automatic t_step;
    int w;
    set_ref(4);
    cyc(2 * WIN + 10);
    chk("R3 fast step", impaired, 1);
    set_ref(8);
    wait_clear(w);
    set_ref(16);
    cyc(2 * WIN + 10);
    chk("R1 slow reference", impaired, 1);
    set_ref(8);
    wait_clear(w);
    chk("R4 recovery after step", impaired, 0);
  endtask

  task automatic t_history;
    int w;
    freq_word = 24'h0A0A0A;
    cyc(800);
    freq_word = 24'h0B0B0B;
    ref_en = 1'b0;
    cyc(2 * WIN + 10);
    chk("R7 holdover word from two periods back", hold, 24'h0A0A0A);
    freq_word = 24'h0E0E0E;
    cyc(300);
    chk("R6 holdover word stable", hold, 24'h0A0A0A);
    set_ref(8);
    wait_clear(w);
    freq_word = 24'h0C0C0C;
    cyc(900);
    freq_word = 24'h0D0D0D;
    ref_en = 1'b0;
    cyc(2 * WIN + 10);
    chk("R6 second holdover word", hold, 24'h0C0C0C);
  endtask

  task automatic t_freeze;
    int w;
    freq_word = 24'h0E0E0E;
    cyc(900);
    set_ref(8);
    freq_word = 24'h0F0F0F;
    wait_clear(w);
    ref_en = 1'b0;
    cyc(2 * WIN + 10);
    chk("R8 impaired word excluded", (hold != 24'h0E0E0E && hold != 24'h0F0F0F) ? 1 : 0, 1);
    chk("R8 hold from earlier history", (hold == 24'h0C0C0C || hold == 24'h0D0D0D) ? 1 : 0, 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(4);
    set_ref(8);
    rst = 1'b0;
    t_reset();
    t_first_lock();
    t_limits();
    t_loss();
    t_step();
    t_history();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule